// File: doc/BRIEF.md
# Up/Down Capture-Reload Timer

A 16-bit timer/counter peripheral held as byte-wide registers on a simple register port. The count advances only on cycles where the count-enable tick is high and the run bit is set. It has two modes. In capture mode the counter runs upward without stopping. A falling edge on an external pin can copy the running count into a 16-bit capture register. In auto-reload mode that same 16-bit register is the reload value. The counter can then run upward or downward.

The count direction in auto-reload mode comes from a down-count enable bit together with the synchronized external pin. The pin is brought through a synchronizer. A falling edge is recognized when the pin is seen high on one tick and low on the next tick. Overflow and capture events set sticky flags, and software clears them. The overflow flag also drives a port.

Top module: `updn_cap_timer`

## Requirements
- R1: After reset, every mapped register reads 00h and ovf_o is 0.
- R2: Register map. C8h is control: bit0 run, bit1 capture mode (0 = auto-reload), bit2 external-enable, bit6 external flag, bit7 overflow flag. C9h is direction control, with bit0 the down-count enable and the other bits reading 0. CAh is capture low, CBh capture high, CCh count low and CDh count high. All are readable and writable, and unmapped addresses read 00h.
- R3: The count changes only on a clock where tick_i is 1 and the run bit is set. Otherwise it holds.
- R4: In capture mode the count increments on each step. A step from FFFFh gives 0000h and sets the overflow flag.
- R5: In capture mode with external-enable set, a falling edge of the pin (high on one tick, low on the next) copies the count as it was before that tick into the capture register and sets the external flag. With external-enable clear, no copy is made and the flag is not set.
- R6: In auto-reload mode the count runs up when the down-count enable is 0, or when it is 1 and the pin is high. A step from FFFFh loads the capture register value and sets the overflow flag.
- R7: In auto-reload mode with down-count enable 1 and the pin low, the count decrements. A step where the count equals the capture register value loads FFFFh and sets the overflow flag.
- R8: A write to either count byte in the same cycle as a tick stores the written byte. No count step occurs in that cycle.
- R9: Flags stay set until software writes 0 to them. A hardware set in the same cycle as a clearing write wins.
- R10: ovf_o equals the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tick_i | input | 1 | Count-enable tick |
| ext_pin_i | input | 1 | External capture / direction pin |
| ovf_o | output | 1 | Overflow flag |

## Verification
The hardest situation to reach is a count step landing exactly on the reload boundary. This is FFFFh when counting up, or the reload value itself when counting down, and it must happen while the direction pin has been settled through the synchronizer. The stimulus preloads the count a few steps short of the boundary and draws the reload value, direction and run length from a fixed-seed random source. It then compares the count and flag against a bench model. Directed cases place a register write on the same clock as a tick. This covers both count-write priority and the flag-clear collision.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;
  localparam logic [7:0] ADDR_CTRL   = 8'hC8;
  localparam logic [7:0] ADDR_DIR    = 8'hC9;
  localparam logic [7:0] ADDR_CAP_LO = 8'hCA;
  localparam logic [7:0] ADDR_CAP_HI = 8'hCB;
  localparam logic [7:0] ADDR_CNT_LO = 8'hCC;
  localparam logic [7:0] ADDR_CNT_HI = 8'hCD;

  localparam int unsigned CTRL_RUN  = 0;
  localparam int unsigned CTRL_CAPM = 1;
  localparam int unsigned CTRL_EXEN = 2;
  localparam int unsigned CTRL_EXTF = 6;
  localparam int unsigned CTRL_OVF  = 7;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  assign level_o = sync_q[STAGES-1];

  // level seen on the previous tick
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     prev_q <= 1'b0;
    else if (tick_i) prev_q <= level_o;

  assign fall_o = tick_i & prev_q & ~level_o;
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             cap_mode_i,
  input  logic             down_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_comb begin
    wrap_o = 1'b0;
    cnt_o  = cnt_i + ONE;
    if (cap_mode_i) begin
      wrap_o = (cnt_i == TOP);
    end else if (down_i) begin
      if (cnt_i == reload_i) begin
        cnt_o  = TOP;
        wrap_o = 1'b1;
      end else begin
        cnt_o = cnt_i - ONE;
      end
    end else if (cnt_i == TOP) begin
      cnt_o  = reload_i;
      wrap_o = 1'b1;
    end
  end
endmodule

// File: rtl/updn_cap_timer.sv
module updn_cap_timer
  import updn_tmr_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              ext_pin_i,
  output logic              ovf_o
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_q, cap_q, cnt_nxt;
  logic run_q, capm_q, exen_q, extf_q, ovf_q, dn_en_q;
  logic pin_level, pin_fall, wrap, down_dir, step, cap_evt;
  logic wr_ctrl, wr_dir, wr_cap_lo, wr_cap_hi, wr_cnt_lo, wr_cnt_hi;
  logic cnt_wr, cap_wr, ctrl_wr;

  assign wr_ctrl   = wr_en_i & (addr_i == ADDR_CTRL);
  assign wr_dir    = wr_en_i & (addr_i == ADDR_DIR);
  assign wr_cap_lo = wr_en_i & (addr_i == ADDR_CAP_LO);
  assign wr_cap_hi = wr_en_i & (addr_i == ADDR_CAP_HI);
  assign wr_cnt_lo = wr_en_i & (addr_i == ADDR_CNT_LO);
  assign wr_cnt_hi = wr_en_i & (addr_i == ADDR_CNT_HI);
  assign cnt_wr    = wr_cnt_lo | wr_cnt_hi;
  assign cap_wr    = wr_cap_lo | wr_cap_hi;
  assign ctrl_wr   = wr_ctrl;

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .tick_i (tick_i),
    .level_o(pin_level),
    .fall_o (pin_fall)
  );

  assign down_dir = ~capm_q & dn_en_q & ~pin_level;
  assign step     = tick_i & run_q & ~cnt_wr;
  assign cap_evt  = pin_fall & capm_q & exen_q;

  tmr_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .cnt_i     (cnt_q),
    .reload_i  (cap_q),
    .cap_mode_i(capm_q),
    .down_i    (down_dir),
    .cnt_o     (cnt_nxt),
    .wrap_o    (wrap)
  );

  // software byte write beats a step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      if (wr_cnt_lo) cnt_q[BYTE_W-1:0]     <= wdata_i;
      if (wr_cnt_hi) cnt_q[CNT_W-1:BYTE_W] <= wdata_i;
    end else if (step) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
    end else if (cap_wr) begin
      if (wr_cap_lo) cap_q[BYTE_W-1:0]     <= wdata_i;
      if (wr_cap_hi) cap_q[CNT_W-1:BYTE_W] <= wdata_i;
    end else if (cap_evt) begin
      cap_q <= cnt_q;
    end
  end

  // hardware set is the later assignment, so it wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      capm_q  <= 1'b0;
      exen_q  <= 1'b0;
      extf_q  <= 1'b0;
      ovf_q   <= 1'b0;
      dn_en_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= wdata_i[CTRL_RUN];
        capm_q <= wdata_i[CTRL_CAPM];
        exen_q <= wdata_i[CTRL_EXEN];
        extf_q <= wdata_i[CTRL_EXTF];
        ovf_q  <= wdata_i[CTRL_OVF];
      end
      if (wr_dir)         dn_en_q <= wdata_i[0];
      if (cap_evt)        extf_q  <= 1'b1;
      if (step && wrap)   ovf_q   <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_RUN]  = run_q;
        rdata_o[CTRL_CAPM] = capm_q;
        rdata_o[CTRL_EXEN] = exen_q;
        rdata_o[CTRL_EXTF] = extf_q;
        rdata_o[CTRL_OVF]  = ovf_q;
      end
      ADDR_DIR:    rdata_o[0] = dn_en_q;
      ADDR_CAP_LO: rdata_o = cap_q[BYTE_W-1:0];
      ADDR_CAP_HI: rdata_o = cap_q[CNT_W-1:BYTE_W];
      ADDR_CNT_LO: rdata_o = cnt_q[BYTE_W-1:0];
      ADDR_CNT_HI: rdata_o = cnt_q[CNT_W-1:BYTE_W];
      default:     rdata_o = '0;
    endcase
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/updn_cap_timer_chk.sv
module updn_cap_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             run_q,
  input logic             capm_q,
  input logic             exen_q,
  input logic             down_dir,
  input logic             cnt_wr,
  input logic             cap_wr,
  input logic             ctrl_wr,
  input logic             pin_fall,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cap_q,
  input logic             ovf_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(tick_i && run_q) && !cnt_wr) |=> $stable(cnt_q));

  // R4
  cap_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_q && !cnt_wr && capm_q && cnt_q == TOP) |=> (cnt_q == '0 && ovf_o));

  // R5
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_fall && capm_q && exen_q && !cap_wr) |=> (cap_q == $past(cnt_q)));

  // R6
  up_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_q && !cnt_wr && !capm_q && !down_dir && cnt_q == TOP)
      |=> (cnt_q == $past(cap_q) && ovf_o));

  // R7
  down_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_q && !cnt_wr && down_dir && cnt_q == cap_q) |=> (cnt_q == TOP && ovf_o));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ctrl_wr) |=> ovf_o);
endmodule

bind updn_cap_timer updn_cap_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .run_q   (run_q),
  .capm_q  (capm_q),
  .exen_q  (exen_q),
  .down_dir(down_dir),
  .cnt_wr  (cnt_wr),
  .cap_wr  (cap_wr),
  .ctrl_wr (ctrl_wr),
  .pin_fall(pin_fall),
  .cnt_q   (cnt_q),
  .cap_q   (cap_q),
  .ovf_o   (ovf_o)
);

// File: tb/updn_cap_timer_tb.sv
module updn_cap_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tick = 1'b0;
  logic       pin = 1'b0;
  logic       ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  updn_cap_timer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .ext_pin_i(pin), .ovf_o(ovf)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd16(input logic [7:0] lo_a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(lo_a, lo); rd(lo_a + 8'd1, hi);
    d = {hi, lo};
  endtask

  task automatic wr16(input logic [7:0] lo_a, input logic [15:0] d);
    wr(lo_a, d[7:0]); wr(lo_a + 8'd1, d[15:8]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); pin = v;
    repeat (4) @(negedge clk);
  endtask

  // {ovf, next}
  function automatic logic [16:0] model_step(input logic [15:0] c, input logic [15:0] rel,
                                             input logic capm, input logic dn);
    if (capm)          return {c == 16'hFFFF, c + 16'd1};
    if (dn)            return (c == rel) ? {1'b1, 16'hFFFF} : {1'b0, c - 16'd1};
    if (c == 16'hFFFF) return {1'b1, rel};
    return {1'b0, c + 16'd1};
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 8'hC8; a <= 8'hCD; a++) begin
      rd(8'(a), b); chk("R1 reset value", {8'h00, b}, 16'h0000);
    end
    chk("R1 ovf_o reset", {15'd0, ovf}, 16'd0);

    // R2 map
    wr16(8'hCA, 16'hA55A); rd16(8'hCA, w); chk("R2 capture regs", w, 16'hA55A);
    wr16(8'hCC, 16'h3CC3); rd16(8'hCC, w); chk("R2 count regs", w, 16'h3CC3);
    wr(8'hC9, 8'hFF); rd(8'hC9, b); chk("R2 direction reg", {8'h00, b}, 16'h0001);
    wr(8'hC9, 8'h00);
    wr(8'hC8, 8'h06); rd(8'hC8, b); chk("R2 control reg", {8'h00, b}, 16'h0006);
    rd(8'hC0, b); chk("R2 unmapped", {8'h00, b}, 16'h0000);

    // R3 stopped / no tick
    wr(8'hC8, 8'h02); wr16(8'hCC, 16'h0010);
    ticks(3); rd16(8'hCC, w); chk("R3 stopped holds", w, 16'h0010);
    wr(8'hC8, 8'h03); repeat (5) @(negedge clk);
    rd16(8'hCC, w); chk("R3 no tick holds", w, 16'h0010);
    ticks(3); rd16(8'hCC, w); chk("R3 three steps", w, 16'h0013);

    // R4 wrap in capture mode, R9/R10 flags
    wr(8'hC8, 8'h02); wr16(8'hCC, 16'hFFFE); wr(8'hC8, 8'h03);
    ticks(2); rd16(8'hCC, w); chk("R4 wrap to zero", w, 16'h0000);
    rd(8'hC8, b); chk("R4 ovf flag", {15'd0, b[7]}, 16'd1);
    chk("R10 ovf_o", {15'd0, ovf}, 16'd1);
    ticks(3); rd(8'hC8, b); chk("R9 flag sticky", {15'd0, b[7]}, 16'd1);
    wr(8'hC8, 8'h03); rd(8'hC8, b); chk("R9 flag cleared", {15'd0, b[7]}, 16'd0);
    chk("R10 ovf_o cleared", {15'd0, ovf}, 16'd0);

    // R9 set wins over clear
    wr(8'hC8, 8'h02); wr16(8'hCC, 16'hFFFF);
    wr(8'hC8, 8'h03);
    @(negedge clk); wr_en = 1'b1; addr = 8'hC8; wdata = 8'h03; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd(8'hC8, b); chk("R9 hw set wins", {15'd0, b[7]}, 16'd1);
    rd16(8'hCC, w); chk("R4 step during ctrl write", w, 16'h0000);

    // R8 count write beats tick
    wr(8'hC8, 8'h03); wr16(8'hCC, 16'h00FF);
    @(negedge clk); wr_en = 1'b1; addr = 8'hCC; wdata = 8'h55; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd16(8'hCC, w); chk("R8 write priority", w, 16'h0055);

    // R5 capture
    wr(8'hC8, 8'h00); wr16(8'hCA, 16'h0000); wr16(8'hCC, 16'h1234);
    set_pin(1'b1); wr(8'hC8, 8'h07);
    ticks(1); set_pin(1'b0); ticks(1);
    rd16(8'hCA, w); chk("R5 captured value", w, 16'h1235);
    rd(8'hC8, b); chk("R5 ext flag", {15'd0, b[6]}, 16'd1);
    rd16(8'hCC, w); chk("R5 count continues", w, 16'h1236);
    wr(8'hC8, 8'h03); wr16(8'hCA, 16'h0000);
    set_pin(1'b1); ticks(1); set_pin(1'b0); ticks(1);
    rd16(8'hCA, w); chk("R5 no capture when disabled", w, 16'h0000);
    rd(8'hC8, b); chk("R5 no flag when disabled", {15'd0, b[6]}, 16'd0);

    // R6 R7 R4 random runs against model
    for (int it = 0; it < 60; it++) begin
      logic [15:0] rel, c;
      logic capm, dn_en, pv, ov, dn;
      logic [16:0] r;
      int n;
      rel = 16'($urandom); capm = ($urandom % 3) == 0;
      dn_en = $urandom % 2; pv = $urandom % 2; n = 1 + $urandom % 12;
      dn = !capm && dn_en && !pv;
      c = dn ? rel + 16'($urandom % 6) : 16'hFFFF - 16'($urandom % 8);
      wr(8'hC8, 8'h00); wr16(8'hCA, rel); wr16(8'hCC, c);
      wr(8'hC9, {7'd0, dn_en}); set_pin(pv);
      wr(8'hC8, capm ? 8'h03 : 8'h01);
      ov = 1'b0;
      for (int k = 0; k < n; k++) begin
        r = model_step(c, rel, capm, dn); ov |= r[16]; c = r[15:0];
      end
      ticks(n);
      rd16(8'hCC, w);
      chk(capm ? "R4 random count" : (dn ? "R7 random count" : "R6 random count"), w, c);
      rd(8'hC8, b);
      chk(capm ? "R4 random ovf" : (dn ? "R7 random ovf" : "R6 random ovf"), {15'd0, b[7]}, {15'd0, ov});
      chk("R10 random ovf_o", {15'd0, ovf}, {15'd0, ov});
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule